// File: doc/BRIEF.md
# Single-Bus Arithmetic, Logic and Shift Unit

This is a purely combinational 16-bit datapath unit for a CPU built around one internal bus. One operand comes from a temporary holding register (operand A). The other comes from the internal bus (operand B). The unit also receives an 8-bit immediate from the instruction, a 5-bit shift count from the instruction, and a 3-bit function select. The control sequencer picks a function on each step, and the result is captured into the buffer register C on the same step.

The unit provides seven functions:

- Forwarding the bus value unchanged, used for register moves, calls and returns.
- Stepping the bus value forward by two, for a 2-byte instruction stride.
- Adding operand A to the sign-extended immediate, for relative jumps.
- Producing the sign-extended immediate alone.
- Three shifts of the bus value: left, logical right and arithmetic right.

Top module: `alsu16`

## Requirements
- R1: With `fsel` = 3'b000 (forward), `result` equals `bus_b`.
- R2: With `fsel` = 3'b001 (step), `result` equals `bus_b` + 2 modulo 2^16, so 16'hFFFF gives 16'h0001.
- R3: With `fsel` = 3'b010 (offset add), `result` equals `opa` plus `imm8` sign-extended to 16 bits, modulo 2^16.
- R4: With `fsel` = 3'b011 (extend), `result[7:0]` equals `imm8` and every bit of `result[15:8]` equals `imm8[7]`.
- R5: With `fsel` = 3'b100 (logical right) and `shamt` N below 16, `result` is `bus_b` moved N places toward bit 0, with zeros in the top N bits.
- R6: With `fsel` = 3'b101 (left) and N below 16, `result` is `bus_b` moved N places toward bit 15, with zeros in the low N bits.
- R7: With `fsel` = 3'b110 (arithmetic right) and N below 16, `result` is `bus_b` moved N places toward bit 0, with the top N bits copied from `bus_b[15]`.
- R8: When `shamt` is 16 or more, both the left and the logical right shift give 16'h0000, and the arithmetic right shift gives sixteen copies of `bus_b[15]`.
- R9: With `fsel` = 3'b111 (unused), `result` is 16'h0000.
- R10: Inputs that the selected function does not use have no effect on `result`. These are `opa` and `imm8` for forward, step and shift; `bus_b` for the offset add and extend; and `shamt` for every function that is not a shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | Operand A from the temporary register |
| bus_b | input | 16 | Operand B from the internal bus |
| imm8 | input | 8 | Signed immediate from the instruction |
| shamt | input | 5 | Shift count from the instruction |
| fsel | input | 3 | Function select |
| result | output | 16 | Value to be loaded into register C |

## Verification
The bench targets carry and sign boundaries that a faulty unit would get wrong:

- Stepping from 16'hFFFF must wrap to 16'h0001. A unit that saturated or dropped the carry would not.
- Adding a negative immediate must borrow across bit 8. A unit that zero-extended the immediate would produce a value 256 too high.
- Shift counts of 0, 15, 16 and 31 are applied to patterns with bit 15 set. An arithmetic shift that filled with zeros, or a count truncated to four bits, would show up as a wrong upper byte or a spurious nonzero result.
- Unused inputs are toggled between otherwise identical vectors. A select decode that leaked `opa` or `shamt` into the wrong function would change the output.

// File: rtl/alsu16.sv
module alsu16 #(
  parameter int W   = 16,
  parameter int KW  = 8,
  parameter int SW  = 5
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  bus_b,
  input  logic [KW-1:0] imm8,
  input  logic [SW-1:0] shamt,
  input  logic [2:0]    fsel,
  output logic [W-1:0]  result
);
  localparam int LW = $clog2(W);
  localparam logic [2:0] F_FWD = 3'b000, F_STEP = 3'b001, F_OFS = 3'b010,
                         F_EXT = 3'b011, F_SHR  = 3'b100, F_SHL = 3'b101,
                         F_ASR = 3'b110;

  logic [W-1:0] kext;
  logic         big;
  logic [W-1:0] shr_v, shl_v, asr_v;
  logic [W-1:0] res;

  assign kext = {{(W-KW){imm8[KW-1]}}, imm8};
  assign big  = (shamt >= SW'(W));

  always_comb begin
    shr_v = bus_b;
    shl_v = bus_b;
    asr_v = bus_b;
    for (int s = 0; s < LW; s++) begin
      if (shamt[s]) begin
        shr_v = shr_v >> (1 << s);
        shl_v = shl_v << (1 << s);
        asr_v = W'($signed(asr_v) >>> (1 << s));
      end
    end
    if (big) begin
      shr_v = '0;
      shl_v = '0;
      asr_v = {W{bus_b[W-1]}};
    end
  end

  always_comb begin
    case (fsel)
      F_FWD:   res = bus_b;
      F_STEP:  res = bus_b + W'(2);
      F_OFS:   res = opa + kext;
      F_EXT:   res = kext;
      F_SHR:   res = shr_v;
      F_SHL:   res = shl_v;
      F_ASR:   res = asr_v;
      default: res = '0;
    endcase
    result = res;

    if (!$isunknown({opa, bus_b, imm8, shamt, fsel})) begin
      // R1
      fwd_chk: assert (fsel != F_FWD || res == bus_b);
      // R2
      step_chk: assert (fsel != F_STEP || W'(res - bus_b) == W'(2));
      // R3
      ofs_chk: assert (fsel != F_OFS || W'(res - opa) == kext);
      // R4
      ext_chk: assert (fsel != F_EXT ||
                       (res[KW-1:0] == imm8 &&
                        (res[W-1:KW] == '0 || res[W-1:KW] == '1) &&
                        res[W-1] == imm8[KW-1]));
      // R5
      shr_fill_chk: assert (fsel != F_SHR || shamt == '0 || res[W-1] == 1'b0);
      // R6
      shl_fill_chk: assert (fsel != F_SHL || shamt == '0 || res[0] == 1'b0);
      // R7
      asr_sign_chk: assert (fsel != F_ASR || res[W-1] == bus_b[W-1]);
      // R8
      big_chk: assert (!big || !(fsel == F_SHR || fsel == F_SHL) || res == '0);
      // R9
      unused_chk: assert (fsel != 3'b111 || res == '0);
    end
  end
endmodule

// File: tb/alsu16_bench.sv
module alsu16_bench;
  logic        clk = 1'b0;
  logic [15:0] opa = '0, bus_b = '0;
  logic [7:0]  imm8 = '0;
  logic [4:0]  shamt = '0;
  logic [2:0]  fsel = '0;
  logic [15:0] result;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  alsu16 u_alsu16 (.opa(opa), .bus_b(bus_b), .imm8(imm8), .shamt(shamt),
                   .fsel(fsel), .result(result));

  function automatic logic [15:0] model(input logic [2:0] f, input logic [15:0] a,
      input logic [15:0] b, input logic [7:0] k, input logic [4:0] n);
    logic [15:0] r;
    int nn;
    nn = int'(n);
    r = '0;
    case (f)
      3'd0: r = b;
      3'd1: r = b + 16'd2;
      3'd2: r = a + {{8{k[7]}}, k};
      3'd3: begin r[7:0] = k; for (int i = 8; i < 16; i++) r[i] = k[7]; end
      3'd4: for (int i = 0; i < 16; i++) r[i] = (i + nn < 16) ? b[i + nn] : 1'b0;
      3'd5: for (int i = 0; i < 16; i++) r[i] = (i - nn >= 0) ? b[i - nn] : 1'b0;
      3'd6: for (int i = 0; i < 16; i++) r[i] = (i + nn < 16) ? b[i + nn] : b[15];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] f, input logic [4:0] n);
    if (f >= 3'd4 && f <= 3'd6 && n >= 5'd16) return "R8";
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b,
      input logic [7:0] k, input logic [4:0] n, input string tg);
    @(posedge clk);
    fsel = f; opa = a; bus_b = b; imm8 = k; shamt = n;
    exp_q.push_back(model(f, a, b, k, n));
    tag_q.push_back(tg);
  endtask

  task automatic vec(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b,
      input logic [7:0] k, input logic [4:0] n);
    drive(f, a, b, k, n, tag_of(f, n));
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (result !== e) begin
        bad++;
        $display("FAIL %s: result=%h expected=%h (fsel=%0d a=%h b=%h k=%h n=%0d)",
                 t, result, e, fsel, opa, bus_b, imm8, shamt);
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: result=%h expected=done", result);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // idle vector: all zero inputs give zero (R1)
    drive(3'd0, 16'h0, 16'h0, 8'h0, 5'd0, "R1");
    vec(3'd0, 16'h1234, 16'hBEEF, 8'h55, 5'd7);
    vec(3'd1, 16'h0, 16'hFFFF, 8'h0, 5'd0);     // R2 wrap
    vec(3'd1, 16'h0, 16'hFFFE, 8'h0, 5'd0);
    vec(3'd2, 16'h0000, 16'h0, 8'h80, 5'd0);    // R3 -> FF80
    vec(3'd2, 16'h7FFF, 16'h0, 8'h01, 5'd0);    // R3 -> 8000
    vec(3'd2, 16'h0100, 16'h0, 8'hFF, 5'd0);    // R3 borrow across bit 8
    vec(3'd3, 16'h0, 16'h0, 8'h80, 5'd0);       // R4
    vec(3'd3, 16'h0, 16'h0, 8'h7F, 5'd0);
    for (int n = 0; n < 32; n++) begin
      vec(3'd4, 16'h0, 16'h8001, 8'h0, 5'(n));  // R5 / R8
      vec(3'd5, 16'h0, 16'h8001, 8'h0, 5'(n));  // R6 / R8
      vec(3'd6, 16'h0, 16'h8001, 8'h0, 5'(n));  // R7 / R8
      vec(3'd6, 16'h0, 16'h7FFE, 8'h0, 5'(n));
    end
    vec(3'd7, 16'hFFFF, 16'hFFFF, 8'hFF, 5'd31); // R9
    // R10: toggle unused inputs
    for (int i = 0; i < 40; i++) begin
      logic [15:0] b;
      b = 16'($urandom);
      drive(3'd0, 16'($urandom), b, 8'($urandom), 5'($urandom), "R10");
      drive(3'd1, 16'($urandom), b, 8'($urandom), 5'($urandom), "R10");
      drive(3'd2, 16'h4321, 16'($urandom), 8'hF0, 5'($urandom), "R10");
      drive(3'd3, 16'($urandom), 16'($urandom), 8'hA5, 5'($urandom), "R10");
      drive(3'd4, 16'($urandom), b, 8'($urandom), 5'd3, "R10");
    end
    for (int i = 0; i < 2000; i++)
      vec(3'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), 5'($urandom));
    @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule